// File: doc/BRIEF.md
# Oscillator Calibration and Divider Sync Sequencer

This block orders the two control actions that bring a clock generator into a known state: an oscillator band calibration, run by an external band-selection engine through a start/done handshake, and a global synchronization pulse that phase-aligns every clock divider. Software requests these actions by writing two self-clearing command bits. One bit asks for a calibration. The other asks for a divider sync on its own. Each bit stays readable as pending until the sequencer accepts it, and then drops to zero.

After reset, a hold-off counter must run out before the first calibration may begin. The counter stands for the long settling wait at power-up. A calibration request made earlier is kept pending and starts on the cycle after the counter expires. A calibration starts only while the reference-valid input is high. Every calibration that completes is followed at once by a divider sync, so software never has to issue the sync separately. A sticky status bit reports that at least one calibration has finished since reset.

Every pin is a plain control or status signal. No data stream passes through the block, so there is no valid/ready interface and no back-pressure.

Top module: `osc_cal_sync_seq`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `cal_start`, `div_sync`, `busy`, `cal_ok` and `cmd_rdata` are all 0.
- R2: A clock edge with `cmd_wr` high sets the calibrate-pending bit when `cmd_wdata[1]` is 1, and sets the sync-pending bit when `cmd_wdata[0]` is 1. A 0 in either bit of `cmd_wdata` has no effect. `cmd_rdata` reads as {calibrate pending, sync pending}, and each bit clears itself on the edge where its request is accepted.
- R3: After reset is released, counting the first rising edge as edge 1, `cal_start` cannot be high before edge HOLDOFF_CYCLES+1. A calibration request that is pending during the hold-off starts exactly at that edge.
- R4: A calibration is accepted only on an edge where `ref_valid` is high. While `ref_valid` is low, the request stays pending in `cmd_rdata[1]`.
- R5: `cal_start` is a single-cycle pulse. When the block is idle and the hold-off has expired, `cal_start` goes high one cycle after the edge that captured the write.
- R6: The edge that samples `cal_done` high while the engine is running makes `div_sync` high for exactly the following cycle.
- R7: A sync-only request makes `div_sync` pulse one cycle after the write is captured. It produces no `cal_start` and leaves `cal_ok` unchanged.
- R8: `busy` is high from the `cal_start` cycle through the `div_sync` cycle, and also during a sync-only pulse. It is low in the cycle after the pulse.
- R9: `cal_ok` becomes 1 in the cycle after the sync that ends a calibration. It then stays 1 until reset.
- R10: When both requests are pending, the calibration runs first. The sync-only request then runs two cycles after the calibration's sync pulse.
- R11: `cal_done` is ignored unless the block is waiting for the engine. A pulse on it while idle produces no `div_sync`.
- R12: Once the hold-off has expired after a reset, no later calibration waits on it. Each one starts one cycle after it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on or general reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_wdata | input | 2 | Command bits: [1] calibrate, [0] sync only |
| cmd_rdata | output | 2 | Pending command bits, same positions as `cmd_wdata` |
| ref_valid | input | 1 | Reference clock is active and stable |
| cal_start | output | 1 | One-cycle start pulse to the band-selection engine |
| cal_done | input | 1 | Completion pulse from the band-selection engine |
| div_sync | output | 1 | One-cycle global divider sync pulse |
| busy | output | 1 | A sequence is in progress |
| cal_ok | output | 1 | At least one calibration has completed since reset |

## Verification
A hold-off counter in a wrong state shows up directly: the first `cal_start` arrives at the wrong edge after reset, so the bench checks that edge number exactly. A command latch or state register in a wrong state shows up within one or two cycles of a write. The symptoms are a pending bit in `cmd_rdata` that fails to clear, a missing or doubled `cal_start` or `div_sync` pulse, or `busy` staying high. A scoreboard records whether each expected sync follows a calibration or stands alone. A sync of the wrong kind, or a lost one, is therefore caught at the pulse itself, and a wrong completion flag is caught one cycle later on `cal_ok`.

// File: rtl/calseq_pkg.sv
package calseq_pkg;
  localparam int CMD_W        = 2;
  localparam int CMD_CAL_BIT  = 1;
  localparam int CMD_SYNC_BIT = 0;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CAL_GO,
    ST_CAL_WAIT,
    ST_SYNC_CAL,
    ST_SYNC_ONLY
  } seq_state_t;
endpackage

// File: rtl/calseq_holdoff.sv
module calseq_holdoff #(
  parameter int HOLDOFF_CYCLES = 100
) (
  input  logic clk,
  input  logic rst_n,
  output logic expired
);
  localparam int CW = $clog2(HOLDOFF_CYCLES + 2);
  localparam logic [CW-1:0] LIMIT = CW'(HOLDOFF_CYCLES);

  logic [CW-1:0] cnt_q;

  // Runs once after reset and then holds at the limit.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign expired = (cnt_q == LIMIT);
endmodule

// File: rtl/calseq_cmd.sv
module calseq_cmd #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] take,
  output logic [W-1:0] pend
);
  // One self-clearing bit per command. A new write wins over a clear
  // on the same edge, so a request is never lost.
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                pend[i] <= 1'b0;
      else if (wr && wdata[i])   pend[i] <= 1'b1;
      else if (take[i])          pend[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/calseq_fsm.sv
module calseq_fsm
  import calseq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cal_pend,
  input  logic             sync_pend,
  input  logic             holdoff_expired,
  input  logic             ref_valid,
  input  logic             cal_done,
  output logic [CMD_W-1:0] take,
  output logic             cal_start,
  output logic             div_sync,
  output logic             busy,
  output logic             cal_ok
);
  seq_state_t st_q, st_d;
  logic       ok_q;
  logic       gate_open, cal_go, sync_go;

  always_comb begin
    // The hold-off only gates until the first calibration completes.
    gate_open = holdoff_expired | ok_q;
    cal_go    = (st_q == ST_IDLE) & cal_pend & ref_valid & gate_open;
    sync_go   = (st_q == ST_IDLE) & ~cal_go & sync_pend;
    take               = '0;
    take[CMD_CAL_BIT]  = cal_go;
    take[CMD_SYNC_BIT] = sync_go;
    st_d = st_q;
    case (st_q)
      ST_IDLE:      if (cal_go) st_d = ST_CAL_GO;
                    else if (sync_go) st_d = ST_SYNC_ONLY;
      ST_CAL_GO:    st_d = ST_CAL_WAIT;
      ST_CAL_WAIT:  if (cal_done) st_d = ST_SYNC_CAL;
      ST_SYNC_CAL:  st_d = ST_IDLE;
      ST_SYNC_ONLY: st_d = ST_IDLE;
      default:      st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      ok_q <= 1'b0;
    end else begin
      st_q <= st_d;
      ok_q <= ok_q | (st_q == ST_SYNC_CAL);
    end
  end

  assign cal_start = (st_q == ST_CAL_GO);
  assign div_sync  = (st_q == ST_SYNC_CAL) || (st_q == ST_SYNC_ONLY);
  assign busy      = (st_q != ST_IDLE);
  assign cal_ok    = ok_q;
endmodule

// File: rtl/osc_cal_sync_seq.sv
module osc_cal_sync_seq
  import calseq_pkg::*;
#(
  parameter int HOLDOFF_CYCLES = 100_000_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic [CMD_W-1:0] cmd_wdata,
  output logic [CMD_W-1:0] cmd_rdata,
  input  logic             ref_valid,
  output logic             cal_start,
  input  logic             cal_done,
  output logic             div_sync,
  output logic             busy,
  output logic             cal_ok
);
  logic             holdoff_expired;
  logic [CMD_W-1:0] pend;
  logic [CMD_W-1:0] take;

  calseq_holdoff #(.HOLDOFF_CYCLES(HOLDOFF_CYCLES)) u_holdoff (
    .clk     (clk),
    .rst_n   (rst_n),
    .expired (holdoff_expired)
  );

  calseq_cmd #(.W(CMD_W)) u_cmd (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (cmd_wr),
    .wdata (cmd_wdata),
    .take  (take),
    .pend  (pend)
  );

  calseq_fsm u_fsm (
    .clk             (clk),
    .rst_n           (rst_n),
    .cal_pend        (pend[CMD_CAL_BIT]),
    .sync_pend       (pend[CMD_SYNC_BIT]),
    .holdoff_expired (holdoff_expired),
    .ref_valid       (ref_valid),
    .cal_done        (cal_done),
    .take            (take),
    .cal_start       (cal_start),
    .div_sync        (div_sync),
    .busy            (busy),
    .cal_ok          (cal_ok)
  );

  assign cmd_rdata = pend;
endmodule

// File: rtl/calseq_chk.sv
module calseq_chk #(
  parameter int HOLDOFF_CYCLES = 100
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_wr,
  input logic [1:0] cmd_rdata,
  input logic       ref_valid,
  input logic       cal_start,
  input logic       cal_done,
  input logic       div_sync,
  input logic       busy,
  input logic       cal_ok
);
  localparam int CW = $clog2(HOLDOFF_CYCLES + 3);
  localparam logic [CW-1:0] LIMIT = CW'(HOLDOFF_CYCLES);

  // Edges since reset release, saturating just past the hold-off.
  logic [CW-1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    since_rst <= '0;
    else if (since_rst <= LIMIT)   since_rst <= since_rst + 1'b1;
  end

  a_r3_no_early_start: assert property (@(posedge clk) disable iff (!rst_n)
    cal_start |-> (since_rst > LIMIT));

  a_r4_start_needs_ref: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cal_start) |-> $past(ref_valid));

  a_r5_start_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    cal_start |=> !cal_start);

  a_r2_cal_bit_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cal_start) && !$past(cmd_wr)) |-> !cmd_rdata[1]);

  a_r6_sync_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    div_sync |=> !div_sync);

  a_r8_busy_covers: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_start || div_sync) |-> busy);

  a_r8_busy_ends_on_sync: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(div_sync));

  a_r9_ok_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cal_ok |=> cal_ok);

  a_r11_done_ignored_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_done && !busy && !cmd_rdata[0]) |=> !div_sync);
endmodule

bind osc_cal_sync_seq calseq_chk #(.HOLDOFF_CYCLES(HOLDOFF_CYCLES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_wr    (cmd_wr),
  .cmd_rdata (cmd_rdata),
  .ref_valid (ref_valid),
  .cal_start (cal_start),
  .cal_done  (cal_done),
  .div_sync  (div_sync),
  .busy      (busy),
  .cal_ok    (cal_ok)
);

// File: tb/tb_osc_cal_sync_seq.sv
`timescale 1ns/1ps
module tb_osc_cal_sync_seq;
  localparam int H = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_wr = 1'b0;
  logic [1:0] cmd_wdata = 2'b00;
  logic [1:0] cmd_rdata;
  logic       ref_valid = 1'b0;
  logic       cal_start;
  logic       cal_done = 1'b0;
  logic       div_sync;
  logic       busy;
  logic       cal_ok;

  int checks = 0;
  int errors = 0;
  int edge_cnt = 0;
  bit saw_cal = 1'b0;
  bit finished = 1'b0;
  int exp_q[$];   // 1 = sync after calibration, 0 = sync-only

  always #10 clk = ~clk;   // 50 MHz

  osc_cal_sync_seq #(.HOLDOFF_CYCLES(H)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
    .cmd_rdata(cmd_rdata), .ref_valid(ref_valid), .cal_start(cal_start),
    .cal_done(cal_done), .div_sync(div_sync), .busy(busy), .cal_ok(cal_ok)
  );

  always @(posedge clk) begin
    if (!rst_n) edge_cnt <= 0;
    else        edge_cnt <= edge_cnt + 1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Monitor: pops the expected kind of every sync pulse.
  always @(negedge clk) begin
    if (!rst_n) saw_cal = 1'b0;
    else begin
      if (cal_start) saw_cal = 1'b1;
      if (div_sync) begin
        if (exp_q.size() == 0) chk(1'b0, "R6/R7 unexpected div_sync", 1, 0);
        else begin
          int e;
          e = exp_q.pop_front();
          chk(int'(saw_cal) == e, "R6/R7 sync kind", int'(saw_cal), e);
        end
        saw_cal = 1'b0;
      end
    end
  end

  task automatic do_write(input logic [1:0] bits);
    cmd_wr = 1'b1; cmd_wdata = bits;
    @(negedge clk);
    cmd_wr = 1'b0; cmd_wdata = 2'b00;
  endtask

  // Called at the negedge where cal_start is seen high.
  task automatic serve_cal(input int lat);
    repeat (lat) begin
      @(negedge clk);
      chk(busy && !div_sync && !cal_start, "R8 busy while engine runs", busy, 1);
    end
    cal_done = 1'b1;
    @(negedge clk);
    cal_done = 1'b0;
    chk(div_sync, "R6 div_sync after cal_done", div_sync, 1);
    chk(busy, "R8 busy during sync", busy, 1);
    @(negedge clk);
    chk(!div_sync, "R6 div_sync one cycle", div_sync, 0);
    chk(!busy, "R8 busy low after sync", busy, 0);
    chk(cal_ok, "R9 cal_ok set", cal_ok, 1);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk({cal_start, div_sync, busy, cal_ok, cmd_rdata} == 6'b0, "R1 outputs in reset",
        int'({cal_start, div_sync, busy, cal_ok, cmd_rdata}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({cal_start, div_sync, busy, cal_ok, cmd_rdata} == 6'b0, "R1 outputs after reset",
        int'({cal_start, div_sync, busy, cal_ok, cmd_rdata}), 0);
  endtask

  // Write a calibrate request at once after reset and check the start edge.
  task automatic holdoff_start();
    bit early;
    early = 1'b0;
    exp_q.push_back(1);
    do_write(2'b10);
    while (edge_cnt < H) begin
      if (cal_start) early = 1'b1;
      @(negedge clk);
    end
    chk(!early && !cal_start, "R3 no start during hold-off", int'(early | cal_start), 0);
    chk(cmd_rdata[1], "R3 request held pending", cmd_rdata[1], 1);
    @(negedge clk);
    chk(cal_start && edge_cnt == H + 1, "R3 start at hold-off expiry", edge_cnt, H + 1);
    chk(!cmd_rdata[1], "R2 calibrate bit self-clears", cmd_rdata[1], 0);
    serve_cal(3);
  endtask

  initial begin
    ref_valid = 1'b1;
    do_reset();
    holdoff_start();

    // R12 / R5: later calibration without hold-off.
    exp_q.push_back(1);
    do_write(2'b10);
    chk(!cal_start, "R5 no start before accept", cal_start, 0);
    @(negedge clk);
    chk(cal_start, "R12 immediate start", cal_start, 1);
    @(negedge clk);
    chk(!cal_start, "R5 start single cycle", cal_start, 0);
    serve_cal(1);

    // R4: reference not valid.
    begin
      bit started;
      started = 1'b0;
      ref_valid = 1'b0;
      do_write(2'b10);
      repeat (8) begin
        if (cal_start) started = 1'b1;
        @(negedge clk);
      end
      chk(!started, "R4 no start without ref", started, 0);
      chk(cmd_rdata[1], "R4 request kept pending", cmd_rdata[1], 1);
      exp_q.push_back(1);
      ref_valid = 1'b1;
      @(negedge clk);
      chk(cal_start, "R4 start once ref valid", cal_start, 1);
      serve_cal(2);
    end

    // R7: sync-only.
    exp_q.push_back(0);
    do_write(2'b01);
    @(negedge clk);
    chk(div_sync && !cal_start, "R7 sync-only pulse", int'({div_sync, cal_start}), 2);
    chk(busy, "R8 busy during sync-only", busy, 1);
    chk(!cmd_rdata[0], "R2 sync bit self-clears", cmd_rdata[0], 0);
    @(negedge clk);
    chk(!div_sync && !busy, "R7 sync-only ends", int'({div_sync, busy}), 0);
    chk(cal_ok, "R7 cal_ok unchanged", cal_ok, 1);

    // R11: stray cal_done while idle.
    cal_done = 1'b1;
    @(negedge clk);
    cal_done = 1'b0;
    chk(!div_sync, "R11 cal_done ignored", div_sync, 0);
    @(negedge clk);
    chk(!div_sync && !busy, "R11 still idle", int'({div_sync, busy}), 0);

    // R2: writing zeros does nothing.
    do_write(2'b00);
    chk(cmd_rdata == 2'b00, "R2 zero write no effect", cmd_rdata, 0);
    @(negedge clk);
    chk(!busy && !cal_start && !div_sync, "R2 zero write stays idle", busy, 0);

    // R10: both requests pending.
    exp_q.push_back(1);
    exp_q.push_back(0);
    do_write(2'b11);
    @(negedge clk);
    chk(cal_start, "R10 calibration first", cal_start, 1);
    chk(cmd_rdata == 2'b01, "R10 sync still pending", cmd_rdata, 1);
    serve_cal(2);
    @(negedge clk);
    chk(div_sync && !cal_start, "R10 sync-only follows", div_sync, 1);
    @(negedge clk);
    chk(cmd_rdata == 2'b00 && !busy, "R10 all served", cmd_rdata, 0);

    // R1 / R3: reset during a calibration re-arms the hold-off.
    do_write(2'b10);
    @(negedge clk);
    chk(cal_start, "R12 start before reset", cal_start, 1);
    do_reset();
    holdoff_start();

    chk(exp_q.size() == 0, "R6/R7 all expected syncs seen", exp_q.size(), 0);
    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule